// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter inside a microcontroller. Software writes a GO control bit. The write is applied on the fourth quarter-phase of the instruction cycle. The sequencer then opens the sample switch and runs a conversion clock. The clock is either an oscillator-derived divider or ticks from an internal RC oscillator. On each clock period the sequencer resolves one bit of a trial code, from the most significant bit down, using a comparator input. When the conversion ends, it writes the result register, raises a completion flag and clears GO, all on the same edge.

The comparator, trial DAC and sample capacitor stay outside the block. The sequencer drives the trial code out to the DAC and reads back one comparator bit that says whether the sampled input is at or above that code. Until a conversion completes, the result register holds the previous result. A conversion can be aborted by writing GO=0, and the flag then stays clear.

Top module: `adc_sar_seq`

## Requirements
- R1: While `rst` is high (synchronous) and on the first cycle after it is released: `go`=0, `done_flag`=0, `result`=0, `dac_code`=0 and `sample_en`=1.
- R2: A write (`go_wr`=1 with value `go_wdata`) is held pending and applied on the clock edge where `q4`=1. That can be the same edge as the write. `go` therefore rises only on an edge where `q4` was high.
- R3: In divider mode (`clk_sel`=0), `sample_en` falls one clock after `go` rises. In RC mode (`clk_sel`=1), the conversion waits for the next `q4` pulse, so with `q4` every 4 clocks `sample_en` falls 4 clocks after `go` rises.
- R4: `sample_en` is 0 for the whole conversion and is 1 whenever `go` is 0.
- R5: Bits are resolved from the MSB down, one per conversion-clock period. `dac_code` is the bits kept so far OR the current trial bit. A trial bit is kept when `cmp_in`=1. With `cmp_in` = (input >= `dac_code`), `result` equals the input.
- R6: A conversion lasts 12 conversion-clock periods. In divider mode, `go` stays high for 1+12·N clocks, where `div_sel` 0,1,2,3 gives N = 2, 8, 32, 64.
- R7: `result` keeps its previous value while `go` is high and changes only on the completion edge.
- R8: At completion, `done_flag` sets on the same edge on which `go` clears. The flag then stays set until a `flag_clr` pulse clears it. A set at completion wins over a clear in the same cycle.
- R9: Writing GO=0 during a conversion aborts it at the next `q4`. `go` drops, `sample_en` returns to 1, `result` is unchanged and `done_flag` stays 0.
- R10: Writing GO=1 while a conversion is running has no effect. The duration stays 1+12·N.
- R11: In RC mode, conversion-clock periods are counted from `rc_tick` pulses, and the result follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| q4 | input | 1 | High on the fourth quarter-phase of each instruction cycle |
| go_wr | input | 1 | Software write strobe for the GO bit |
| go_wdata | input | 1 | Value written to GO |
| flag_clr | input | 1 | Software clear of the completion flag |
| clk_sel | input | 1 | Conversion clock source: 0 divider, 1 RC ticks |
| div_sel | input | 2 | Divider ratio select (2, 8, 32, 64 clocks) |
| rc_tick | input | 1 | One-clock pulse per RC oscillator period |
| cmp_in | input | 1 | Comparator: 1 when the sampled input >= dac_code |
| dac_code | output | NBITS | Trial code for the DAC |
| sample_en | output | 1 | Sample switch closed (sampling) |
| go | output | 1 | Conversion in progress |
| done_flag | output | 1 | Completion interrupt flag |
| result | output | NBITS | Last completed conversion result |

## Verification
The bench measures how long GO stays high for every divider ratio. A sequencer that miscounts conversion periods, or that restarts on a second GO=1 write, shows up as a wrong duration. It counts the clocks between GO rising and the sample switch opening, in both clock modes. A design that skipped the extra instruction cycle in RC mode would open the switch too early. It watches the result register for the whole conversion and checks the code it settles on. An early load or a wrong bit order would show there. It also aborts a long conversion. A design that still completed would set the flag or overwrite the result afterwards.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_tad_gen.sv
// Conversion-clock tick source: a programmable divider or external RC ticks.
module adc_tad_gen #(
  parameter int unsigned DIV0 = 2,
  parameter int unsigned DIV1 = 8,
  parameter int unsigned DIV2 = 32,
  parameter int unsigned DIV3 = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clk_sel,
  input  logic [1:0] div_sel,
  input  logic       rc_tick,
  output logic       tick
);
  localparam int unsigned MAX01  = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int unsigned MAX23  = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int unsigned MAXDIV = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W  = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (div_sel)
      2'd0:    last = CNT_W'(DIV0 - 1);
      2'd1:    last = CNT_W'(DIV1 - 1);
      2'd2:    last = CNT_W'(DIV2 - 1);
      default: last = CNT_W'(DIV3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run || clk_sel) begin
      cnt <= '0;
    end else if (cnt == last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (clk_sel ? rc_tick : (cnt == last));
endmodule

// File: rtl/adc_sar_reg.sv
// Successive-approximation register: MSB-first trial and keep.
module adc_sar_reg #(
  parameter int unsigned NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] value
);
  logic [NBITS-1:0] acc;
  logic [NBITS-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      mask <= '0;
    end else if (start) begin
      acc  <= '0;
      mask <= {1'b1, {(NBITS-1){1'b0}}};
    end else if (step && (mask != '0)) begin
      if (cmp_in) acc <= acc | mask;
      mask <= mask >> 1;
    end
  end

  assign trial = acc | mask;
  assign value = acc;
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int unsigned NBITS     = 10,
  parameter int unsigned CONV_TADS = 12,
  parameter int unsigned DIV0      = 2,
  parameter int unsigned DIV1      = 8,
  parameter int unsigned DIV2      = 32,
  parameter int unsigned DIV3      = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q4,
  input  logic             go_wr,
  input  logic             go_wdata,
  input  logic             flag_clr,
  input  logic             clk_sel,
  input  logic [1:0]       div_sel,
  input  logic             rc_tick,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic             sample_en,
  output logic             go,
  output logic             done_flag,
  output logic [NBITS-1:0] result
);
  import adc_seq_pkg::*;

  localparam int unsigned TW = $clog2(CONV_TADS);
  localparam logic [TW-1:0] LAST_TAD  = TW'(CONV_TADS - 1);
  localparam logic [TW-1:0] LAST_STEP = TW'(NBITS - 1);

  seq_state_t       state;
  logic [TW-1:0]    tadc;
  logic             pend_v;
  logic             pend_d;
  logic             wr_now;
  logic             wr_val;
  logic             tick;
  logic             conv_start;
  logic             abort;
  logic             sar_step;
  logic [NBITS-1:0] sar_value;

  // A write in the same cycle as q4 overrides any pending one.
  assign wr_now = go_wr | pend_v;
  assign wr_val = go_wr ? go_wdata : pend_d;
  assign abort  = q4 && wr_now && !wr_val && (state != ST_IDLE);

  assign conv_start = (state == ST_WAIT) && !abort && (!clk_sel || q4);
  assign sar_step   = (state == ST_CONV) && !abort && tick && (tadc <= LAST_STEP);

  adc_tad_gen #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) u_tad (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_CONV),
    .clk_sel (clk_sel),
    .div_sel (div_sel),
    .rc_tick (rc_tick),
    .tick    (tick)
  );

  adc_sar_reg #(.NBITS(NBITS)) u_sar (
    .clk    (clk),
    .rst    (rst),
    .start  (conv_start),
    .step   (sar_step),
    .cmp_in (cmp_in),
    .trial  (dac_code),
    .value  (sar_value)
  );

  // Pending software write, consumed on every q4.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_d <= 1'b0;
    end else if (q4) begin
      pend_v <= 1'b0;
    end else if (go_wr) begin
      pend_v <= 1'b1;
      pend_d <= go_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tadc      <= '0;
      go        <= 1'b0;
      sample_en <= 1'b1;
      done_flag <= 1'b0;
      result    <= '0;
    end else begin
      if (flag_clr) done_flag <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (q4 && wr_now && wr_val) begin
            go    <= 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (abort) begin
            go    <= 1'b0;
            state <= ST_IDLE;
          end else if (conv_start) begin
            sample_en <= 1'b0;
            tadc      <= '0;
            state     <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (abort) begin
            go        <= 1'b0;
            sample_en <= 1'b1;
            state     <= ST_IDLE;
          end else if (tick) begin
            if (tadc == LAST_TAD) begin
              result    <= sar_value;
              done_flag <= 1'b1;
              go        <= 1'b0;
              sample_en <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              tadc <= tadc + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int unsigned NBITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             q4,
  input logic             sample_en,
  input logic             go,
  input logic             done_flag,
  input logic [NBITS-1:0] result
);
  a_r2_go_rises_on_q4: assert property (@(posedge clk) disable iff (rst)
    $rose(go) |-> $past(q4));

  a_r4_sampling_when_idle: assert property (@(posedge clk) disable iff (rst)
    !go |-> sample_en);

  a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
    (go && $past(go)) |-> $stable(result));

  a_r8_flag_with_go_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $fell(go));

  a_r9_no_flag_while_running: assert property (@(posedge clk) disable iff (rst)
    (go && $past(go)) |-> ($past(done_flag) || !done_flag || !$rose(done_flag)));
endmodule

bind adc_sar_seq adc_sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .q4        (q4),
  .sample_en (sample_en),
  .go        (go),
  .done_flag (done_flag),
  .result    (result)
);

// File: tb/test_adc_sar_seq.sv
`timescale 1ns/1ps
module test_adc_sar_seq;
  localparam int NB = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          q4 = 1'b0;
  logic          go_wr = 1'b0;
  logic          go_wdata = 1'b0;
  logic          flag_clr = 1'b0;
  logic          clk_sel = 1'b0;
  logic [1:0]    div_sel = 2'd0;
  logic          rc_tick = 1'b0;
  logic          cmp_in;
  logic [NB-1:0] dac_code;
  logic          sample_en;
  logic          go;
  logic          done_flag;
  logic [NB-1:0] result;
  logic [NB-1:0] vin = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Comparator model: input at or above the trial code.
  assign cmp_in = (vin >= dac_code);

  adc_sar_seq i_adc_sar_seq (
    .clk(clk), .rst(rst), .q4(q4), .go_wr(go_wr), .go_wdata(go_wdata),
    .flag_clr(flag_clr), .clk_sel(clk_sel), .div_sel(div_sel),
    .rc_tick(rc_tick), .cmp_in(cmp_in), .dac_code(dac_code),
    .sample_en(sample_en), .go(go), .done_flag(done_flag), .result(result)
  );

  int ph = 0;
  int rc = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    q4 = (ph == 3);
    rc = (rc + 1) % 5;
    rc_tick = (rc == 4);
  end

  function automatic int ratio(input logic [1:0] s);
    case (s)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic write_go(input logic v);
    @(negedge clk);
    go_wr = 1'b1;
    go_wdata = v;
    @(negedge clk);
    go_wr = 1'b0;
  endtask

  // Starts a conversion and measures it: GO-high clocks, clocks with
  // GO high and switch still closed, and whether result ever moved.
  task automatic run_conv(input bit poke, output int dur, output int sdel,
                          output bit held);
    logic [NB-1:0] old;
    int w;
    write_go(1'b1);
    w = 0;
    while (!go && w < 20) begin
      @(negedge clk);
      w++;
    end
    dur = 0; sdel = 0; held = 1; old = result;
    while (go) begin
      dur++;
      if (sample_en) sdel++;
      if (result != old) held = 0;
      go_wr = poke && (dur == 3);
      go_wdata = 1'b1;
      @(negedge clk);
    end
    go_wr = 1'b0;
  endtask

  // {div_sel, input}
  localparam logic [11:0] VEC [6] = '{
    {2'd0, 10'h3FF}, {2'd1, 10'h000}, {2'd0, 10'h2AA},
    {2'd2, 10'h155}, {2'd3, 10'h201}, {2'd1, 10'h1FF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int dur, sdel;
    bit held;
    logic [NB-1:0] keep;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(go == 0 && done_flag == 0 && sample_en == 1, "R1 control", {go, done_flag, sample_en}, 1);
    check(result == 0 && dac_code == 0, "R1 data", int'(result) + int'(dac_code), 0);

    // Main table walk in divider mode.
    for (int i = 0; i < 6; i++) begin
      div_sel = VEC[i][11:10];
      vin = VEC[i][9:0];
      run_conv(1'b0, dur, sdel, held);
      check(dur == 1 + 12 * ratio(div_sel), "R6 duration", dur, 1 + 12 * ratio(div_sel));
      check(sdel == 1, "R3 divider start delay", sdel, 1);
      check(held, "R7 result held", 0, 1);
      check(result == vin, "R5 result", result, vin);
      check(done_flag == 1 && sample_en == 1, "R8 flag / R4 sampling", {done_flag, sample_en}, 3);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      check(done_flag == 0, "R8 flag cleared", done_flag, 0);
    end

    // R8: flag persists without a clear.
    div_sel = 2'd0; vin = 10'h0F0;
    run_conv(1'b0, dur, sdel, held);
    repeat (50) @(negedge clk);
    check(done_flag == 1, "R8 flag sticky", done_flag, 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;

    // R10: second GO=1 during a run is ignored.
    div_sel = 2'd0; vin = 10'h321;
    run_conv(1'b1, dur, sdel, held);
    check(dur == 25, "R10 duration with extra GO", dur, 25);
    check(result == vin, "R10 result", result, vin);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;

    // R3/R11: RC clock source.
    clk_sel = 1'b1; vin = 10'h1A5;
    run_conv(1'b0, dur, sdel, held);
    check(sdel == 4, "R3 RC start delay", sdel, 4);
    check(result == vin, "R11 RC result", result, vin);
    check(held, "R11 RC result held", 0, 1);
    clk_sel = 1'b0;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;

    // R9: abort a long conversion.
    keep = result;
    div_sel = 2'd3; vin = 10'h0AA;
    write_go(1'b1);
    repeat (40) @(negedge clk);
    check(go == 1 && sample_en == 0, "R4 converting", {go, sample_en}, 2);
    write_go(1'b0);
    repeat (8) @(negedge clk);
    check(go == 0 && sample_en == 1, "R9 aborted idle", {go, sample_en}, 1);
    repeat (900) @(negedge clk);
    check(done_flag == 0, "R9 no flag", done_flag, 0);
    check(result == keep, "R9 result kept", result, keep);

    // R2: a pending GO is applied only at q4.
    @(negedge clk);
    while (q4) @(negedge clk);
    go_wr = 1'b1; go_wdata = 1'b1;
    @(negedge clk); go_wr = 1'b0;
    check(!(go && !q4), "R2 no early start", go, 0);
    repeat (6) @(negedge clk);
    check(go == 1, "R2 start after q4", go, 1);

    summary();
  end
endmodule